// File: doc/BRIEF.md
# Retrace-Loaded Scanline Buffer Port

This block is the read side of a set of scanline buffers that feed a raster scanner over one shared 32-bit bus. The bus has two jobs. While the scanner is in horizontal or vertical retrace, the bus carries a start offset, and the buffer named by the select input captures it. During active display the same bus carries pixel words, and the selected buffer drives them. Retrace therefore also works as the output enable for the buffers.

Each buffer steps its own read offset forward one word per clock while it is selected in active time. No read strobe is needed. The storage behind each buffer is a simple dual-port array. A memory arbiter can refill it through a separate write port at any time, including while the scanner is reading.

In this model the shared bus is split into an input half and an output half. A buffer that does not drive the bus contributes zero to the output mux. Buffer depth must be a power of two so that the read offset wraps naturally.

Top module: `scanbuf_port`

## Requirements
- R1: While reset is held, and after it releases, `bus_out` is zero and every read offset is zero.
- R2: `bus_out` is all zero in every cycle in which `retrace` is high, whatever the buffer contents are.
- R3: On each clock edge where `retrace` is high, the buffer whose index equals `buf_sel` captures the low log2(DEPTH) bits of `bus_in` as its pending start offset. The upper bus bits are ignored, and if retrace lasts several cycles the last value captured wins.
- R4: At the first clock edge with `retrace` low, every buffer holding a pending offset moves its read offset to that value. The bus stays zero for that one cycle, and the word at the start offset appears in the next cycle.
- R5: After the load, the selected buffer reads one word per clock and advances its offset by one, with no other control input. Output n (n ≥ 1) after the load edge is the word at start+n−1.
- R6: A buffer that is not selected during active time keeps its offset and drives nothing. When it is later selected, the word at its held offset appears in the cycle right after the edge that first samples the new select.
- R7: The read offset wraps from DEPTH−1 to 0.
- R8: A write through the write port (`wr_buf` names the buffer, `wr_addr` the word) takes effect at the clock edge while reads go on. A word written before the reader reaches it is read with its new value.
- R9: A buffer that captured no offset during a retrace continues reading from where it stopped before that retrace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe from the memory arbiter |
| wr_buf | input | SEL_W | Buffer index for the write |
| wr_addr | input | AW | Word index for the write |
| wr_data | input | DW | Write data |
| retrace | input | 1 | High during retrace; low means active display |
| buf_sel | input | SEL_W | Selects the buffer that loads an offset or drives data |
| bus_in | input | DW | Shared bus as seen by the buffers (offset during retrace) |
| bus_out | output | DW | Shared bus as driven by the selected buffer |

## Verification
The assertions take three things for granted about the inputs. `buf_sel` always names an existing buffer. A write never targets the word that the selected buffer reads at the same edge. When a buffer is re-selected after being idle, the offset it held is the one it stopped at. The stimulus follows these rules in every sequence: it keeps the select in range, it places each overwrite several words ahead of the reader, and it switches the select only to a buffer that has just been loaded or never read. Expected words come from a pattern function in the bench plus a copy of every write the bench issues.

// File: rtl/scanbuf_pkg.sv
package scanbuf_pkg;
  parameter int unsigned SB_DATA_W  = 32;
  parameter int unsigned SB_DEPTH   = 256;
  parameter int unsigned SB_NUM_BUF = 2;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scanbuf_mem.sv
module scanbuf_mem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      arr[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= arr[raddr];
    end
  end
endmodule

// File: rtl/scanbuf_lane.sv
module scanbuf_lane #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retrace,
  input  logic          sel_me,
  input  logic [AW-1:0] bus_off,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          drive_ok
);
  logic [AW-1:0] start_q, start_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          pend_q, pend_d;
  logic          vld_q, vld_d;
  logic          do_load;

  assign do_load = !retrace && pend_q;
  assign rd_en   = !retrace && !pend_q && sel_me;
  assign rd_addr = ptr_q;
  assign drive_ok = vld_q;

  always_comb begin
    start_d = start_q;
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    vld_d   = vld_q;
    if (retrace) begin
      if (sel_me) begin
        start_d = bus_off;
        pend_d  = 1'b1;
      end
    end else if (do_load) begin
      ptr_d  = start_q;
      pend_d = 1'b0;
      vld_d  = 1'b0;
    end else if (rd_en) begin
      ptr_d = ptr_q + AW'(1);
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
    end
  end

  assert_offset_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !retrace) |=> (ptr_q == $past(start_q)) && !vld_q);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrace && sel_me && !pend_q) |=> (ptr_q == $past(ptr_q) + AW'(1)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!retrace && !sel_me && !pend_q) |=> $stable(ptr_q));
endmodule

// File: rtl/scanbuf_outmux.sv
module scanbuf_outmux #(
  parameter int unsigned DW = 32,
  parameter int unsigned NB = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NB-1:0]         en,
  input  logic [NB-1:0][DW-1:0] word,
  output logic [DW-1:0]         bus_out
);
  always_comb begin
    bus_out = '0;
    for (int b = 0; b < NB; b++) begin
      bus_out = bus_out | (word[b] & {DW{en[b]}});
    end
  end

  assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));
endmodule

// File: rtl/scanbuf_port.sv
module scanbuf_port
  import scanbuf_pkg::*;
#(
  parameter int unsigned DW      = SB_DATA_W,
  parameter int unsigned DEPTH   = SB_DEPTH,
  parameter int unsigned NUM_BUF = SB_NUM_BUF,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned SEL_W  = sel_width(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_buf,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             retrace,
  input  logic [SEL_W-1:0] buf_sel,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    bus_out
);
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q = rst_sync_q[1];

  logic [AW-1:0] bus_off;
  logic          unused_bus_hi;
  assign bus_off       = bus_in[AW-1:0];
  assign unused_bus_hi = ^bus_in[DW-1:AW];

  logic [NUM_BUF-1:0]         drive_en;
  logic [NUM_BUF-1:0][DW-1:0] lane_word;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_lane
    logic          sel_me;
    logic          we;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          drive_ok;

    assign sel_me = (buf_sel == SEL_W'(b));
    assign we     = wr_en && (wr_buf == SEL_W'(b));

    scanbuf_lane #(.AW(AW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_q),
      .retrace  (retrace),
      .sel_me   (sel_me),
      .bus_off  (bus_off),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .drive_ok (drive_ok)
    );

    scanbuf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (lane_word[b])
    );

    assign drive_en[b] = !retrace && sel_me && drive_ok;
  end

  scanbuf_outmux #(.DW(DW), .NB(NUM_BUF)) u_mux (
    .clk     (clk),
    .rst_n   (rst_q),
    .en      (drive_en),
    .word    (lane_word),
    .bus_out (bus_out)
  );

  assert_retrace_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q)
    retrace |-> (bus_out == '0));
endmodule

// File: tb/scanbuf_port_tb.sv
module scanbuf_port_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int DEPTH = 256;
  localparam int NB    = 2;
  localparam int AW    = 8;
  localparam int SW    = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [SW-1:0] wr_buf;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          retrace;
  logic [SW-1:0] buf_sel;
  logic [DW-1:0] bus_in;
  logic [DW-1:0] bus_out;

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] img [NB][DEPTH];

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  scanbuf_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
    .wr_addr(wr_addr), .wr_data(wr_data), .retrace(retrace),
    .buf_sel(buf_sel), .bus_in(bus_in), .bus_out(bus_out)
  );

  function automatic logic [DW-1:0] pat(input int b, input int i);
    logic [7:0] ii;
    ii = 8'(i);
    return {8'(b + 1), ii, ~ii, ii ^ 8'h5A};
  endfunction

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: bus_out=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one call per clock; the expected bus value after the coming edge is queued
  task automatic step(input logic rt, input int sl, input logic [DW-1:0] bi,
                      input logic we, input int wb, input int wa, input logic [DW-1:0] wd,
                      input logic [DW-1:0] ex, input string tag);
    item_t it;
    @(negedge clk);
    retrace = rt;
    buf_sel = SW'(sl);
    bus_in  = bi;
    wr_en   = we;
    wr_buf  = SW'(wb);
    wr_addr = AW'(wa);
    wr_data = wd;
    if (we) img[wb][wa] = wd;
    it.exp = ex;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic active(input int sl, input logic [DW-1:0] ex, input string tag);
    step(1'b0, sl, 32'hDEAD_BEEF, 1'b0, 0, 0, '0, ex, tag);
  endtask

  task automatic blank(input int sl, input logic [DW-1:0] bi, input string tag);
    step(1'b1, sl, bi, 1'b0, 0, 0, '0, '0, tag);
  endtask

  // monitor: samples a quarter period after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(bus_out, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: bus_out=%h expected=finished run", bus_out);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retrace = 1'b0; buf_sel = '0; bus_in = '0;
    wr_en = 1'b0; wr_buf = '0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check(bus_out, '0, "R1 reset");
    @(negedge clk);
    retrace = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // fill both buffers during retrace; R2: bus stays zero throughout
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < DEPTH; i++) begin
        step(1'b1, 0, 32'hFFFF_FFFF, 1'b1, b, i, pat(b, i), '0, "R2 fill");
      end
    end

    // R3: offsets captured per select; upper bus bits ignored
    blank(0, 32'hABCD_EF0A, "R2 load0");
    blank(1, 32'h1234_5632, "R2 load1");
    // R4: zero on load cycle, then start word; R5 stepping; R8 write ahead
    for (int n = 0; n < 12; n++) begin
      logic [DW-1:0] ex;
      if (n == 0) ex = '0;
      else if (10 + n - 1 == 20) ex = 32'hC0FF_EE20;
      else ex = pat(0, 10 + n - 1);
      if (n == 2)
        step(1'b0, 0, 32'h0, 1'b1, 0, 20, 32'hC0FF_EE20, ex, "R8 write-ahead/R5");
      else
        active(0, ex, (n == 0) ? "R4 load cycle" : (n == 1) ? "R4 first word" : "R5 advance");
    end
    // R6: buffer 1 held its loaded offset 50 while unselected
    for (int n = 0; n < 4; n++) active(1, pat(1, 50 + n), "R6 resume held offset");

    // R3: last value in a multi-cycle retrace wins
    blank(0, 32'h5, "R2 r3a");
    blank(0, 32'h6, "R2 r3b");
    blank(0, 32'h7, "R2 r3c");
    active(0, '0, "R4 load cycle");
    active(0, pat(0, 7), "R3 last value wins");
    active(0, pat(0, 8), "R5 advance");

    // R9: retrace that loads only buffer 1 leaves buffer 0 continuing
    blank(1, 32'd100, "R2 other sel");
    active(0, pat(0, 9), "R9 continue");
    active(0, pat(0, 10), "R9 continue");

    // R7: wrap
    blank(1, 32'd254, "R2 wrap load");
    active(1, '0, "R4 load cycle");
    active(1, pat(1, 254), "R7 wrap");
    active(1, pat(1, 255), "R7 wrap");
    active(1, pat(1, 0), "R7 wrap");
    active(1, pat(1, 1), "R7 wrap");

    blank(0, 32'h0, "R2 end");
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule